// File: doc/BRIEF.md
# Signed Eight-Term Reduction Tree with Split Positive/Negative Paths

This block takes eight terms per cycle, each given as an unsigned magnitude and a separate sign bit, and produces their signed sum as a two's-complement number. It serves as the final reduction stage for one output row of a lookup-based matrix engine. The upstream logic supplies the terms, and downstream logic consumes the sum.

Each term is steered by its sign bit into one of two unsigned adder trees. A clear sign sends the magnitude to the positive tree, and a set sign sends it to the negative tree. The tree that does not receive the term gets a zero in that slot. Both trees are binary and pipelined, with one register level per tree level, and each level is one bit wider than the level before it. A single registered subtractor then forms positive-total minus negative-total. No other stage handles signed arithmetic. The pipeline has no stalls: it accepts a new group of terms on every cycle and marks the result with a valid flag delayed by the same amount.

The block has no state machine. Its only sequencing is the fixed four-stage pipeline and the matching chain of valid bits.

Top module: `sm_dual_tree`

## Requirements
- R1: A group sampled with `in_valid` high at a rising edge appears on `out_sum`, with `out_valid` high, just after the third rising edge that follows it. The fixed latency is therefore 4 cycles. Groups may arrive on consecutive cycles.
- R2: `out_sum` equals the sum over terms i = 0..7 of +mag(i) when sign(i) = 0, or −mag(i) when sign(i) = 1. Term i's magnitude is `in_mag[i*MAG_W +: MAG_W]` and its sign is `in_sign[i]`.
- R3: A term with sign 0 adds to the result, and a term with sign 1 subtracts from it. No term ever reaches both trees.
- R4: A term with magnitude 0 leaves the result unchanged, whatever its sign bit.
- R5: While `rst_n` is low, `out_valid` and `out_sum` are 0.
- R6: The full-scale extremes do not wrap. With MAG_W = 8, eight magnitudes of 255 give +2040 when all signs are 0 and −2040 when all signs are 1.
- R7: Idle cycles pass through in order. The pattern of `out_valid` is the pattern of `in_valid` shifted by 4 cycles.
- R8: When the positive and negative totals are equal, `out_sum` is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current group of terms as valid |
| in_mag | input | NUM_TERMS*MAG_W | Term magnitudes; term i occupies bits i*MAG_W +: MAG_W |
| in_sign | input | NUM_TERMS | Term signs; bit i set means term i is negative |
| out_valid | output | 1 | Marks `out_sum` as holding a result |
| out_sum | output | MAG_W+log2(NUM_TERMS)+1 | Two's-complement sum of the signed terms |

## Verification
Every result is due just after the fourth rising edge counted from the edge that samples its input, with the sampling edge counted as the first. The bench applies a new group of terms on each falling edge. On falling edge c it compares the outputs with the group it applied on falling edge c−4, so the results are checked back to back at full throughput. A directed pattern of valid and idle cycles checks `out_valid` against the same four-cycle offset. The reset state is checked while reset is still held.

// File: rtl/sm_tree_pkg.sv
package sm_tree_pkg;
    localparam int DEF_TERMS = 8;
    localparam int DEF_MAG_W = 8;

    // depth of a binary reduction over n leaves
    function automatic int tree_depth(input int n);
        return $clog2(n);
    endfunction
endpackage

// File: rtl/sm_steer.sv
module sm_steer #(
    parameter int NUM_TERMS = sm_tree_pkg::DEF_TERMS,
    parameter int MAG_W     = sm_tree_pkg::DEF_MAG_W
) (
    input  logic [NUM_TERMS*MAG_W-1:0] mag_flat,
    input  logic [NUM_TERMS-1:0]       sign_bits,
    output logic [MAG_W-1:0]           pos_leaf [NUM_TERMS],
    output logic [MAG_W-1:0]           neg_leaf [NUM_TERMS]
);
    // a term lands in exactly one tree; the other tree sees zero
    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_term
        logic [MAG_W-1:0] m;
        assign m           = mag_flat[i*MAG_W +: MAG_W];
        assign pos_leaf[i] = sign_bits[i] ? '0 : m;
        assign neg_leaf[i] = sign_bits[i] ? m  : '0;
    end
endmodule

// File: rtl/sm_utree.sv
module sm_utree #(
    parameter int  NUM_TERMS = sm_tree_pkg::DEF_TERMS,
    parameter int  MAG_W     = sm_tree_pkg::DEF_MAG_W,
    localparam int LEVELS    = sm_tree_pkg::tree_depth(NUM_TERMS),
    localparam int SUM_W     = MAG_W + LEVELS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] leaf [NUM_TERMS],
    output logic [SUM_W-1:0] total
);
    // one register per node; each level one bit wider than the one below
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int CNT = NUM_TERMS >> (l + 1);
        localparam int OW  = MAG_W + l + 1;
        for (genvar i = 0; i < CNT; i++) begin : g_node
            logic [OW-2:0] a, b;
            logic [OW-1:0] q;
            if (l == 0) begin : g_leaf
                assign a = leaf[2*i];
                assign b = leaf[2*i+1];
            end else begin : g_inner
                assign a = g_lvl[l-1].g_node[2*i].q;
                assign b = g_lvl[l-1].g_node[2*i+1].q;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= {1'b0, a} + {1'b0, b};
            end
        end
    end

    assign total = g_lvl[LEVELS-1].g_node[0].q;
endmodule

// File: rtl/sm_final_sub.sv
module sm_final_sub #(
    parameter int  IN_W  = 11,
    localparam int OUT_W = IN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  pos_total,
    input  logic [IN_W-1:0]  neg_total,
    output logic [OUT_W-1:0] diff_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) diff_q <= '0;
        else        diff_q <= {1'b0, pos_total} - {1'b0, neg_total};
    end

    // R3, R6: sign of the result follows which total was larger, no wrap
    assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($signed(diff_q) < 0) == ($past(neg_total) > $past(pos_total))));

    // R8: balanced totals cancel exactly
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_total == neg_total) |=> (diff_q == '0));
endmodule

// File: rtl/sm_dual_tree.sv
module sm_dual_tree #(
    parameter int  NUM_TERMS = sm_tree_pkg::DEF_TERMS,
    parameter int  MAG_W     = sm_tree_pkg::DEF_MAG_W,
    localparam int LEVELS    = sm_tree_pkg::tree_depth(NUM_TERMS),
    localparam int TREE_W    = MAG_W + LEVELS,
    localparam int OUT_W     = TREE_W + 1,
    localparam int LAT       = LEVELS + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_TERMS*MAG_W-1:0] in_mag,
    input  logic [NUM_TERMS-1:0]       in_sign,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           out_sum
);
    logic [MAG_W-1:0]  pos_leaf [NUM_TERMS];
    logic [MAG_W-1:0]  neg_leaf [NUM_TERMS];
    logic [TREE_W-1:0] pos_total, neg_total;
    logic [LAT-1:0]    vld_pipe;

    sm_steer #(.NUM_TERMS(NUM_TERMS), .MAG_W(MAG_W)) u_steer (
        .mag_flat (in_mag),
        .sign_bits(in_sign),
        .pos_leaf (pos_leaf),
        .neg_leaf (neg_leaf)
    );

    sm_utree #(.NUM_TERMS(NUM_TERMS), .MAG_W(MAG_W)) u_pos_tree (
        .clk(clk), .rst_n(rst_n), .leaf(pos_leaf), .total(pos_total)
    );

    sm_utree #(.NUM_TERMS(NUM_TERMS), .MAG_W(MAG_W)) u_neg_tree (
        .clk(clk), .rst_n(rst_n), .leaf(neg_leaf), .total(neg_total)
    );

    sm_final_sub #(.IN_W(TREE_W)) u_sub (
        .clk(clk), .rst_n(rst_n),
        .pos_total(pos_total), .neg_total(neg_total),
        .diff_q(out_sum)
    );

    // valid travels alongside the data, one bit per stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
    end
    assign out_valid = vld_pipe[LAT-1];

    // edges seen since reset, saturating; keeps $past inside the live window
    logic [3:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q < 15) cyc_q <= cyc_q + 4'd1;
    end

    // R1, R7: valid emerges a fixed number of cycles later
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= LAT) |-> (out_valid == $past(in_valid, LAT)));

    // R3: the steering never feeds one term into both trees
    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_chk
        assert_one_tree_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !((pos_leaf[i] != '0) && (neg_leaf[i] != '0)));
        assert_no_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((pos_leaf[i] | neg_leaf[i]) == in_mag[i*MAG_W +: MAG_W]));
    end
endmodule

// File: tb/sim_sm_dual_tree.sv
`timescale 1ns/1ps
module sim_sm_dual_tree;
    localparam int N_VEC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_mag = '0;
    logic [7:0]  in_sign = '0;
    logic        out_valid;
    logic [11:0] out_sum;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sm_dual_tree u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_mag(in_mag), .in_sign(in_sign),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    // magnitudes (term i at byte i), signs, expected signed sum
    localparam logic [63:0] V_MAG [N_VEC] = '{
        64'h0101010101010101, 64'h0807060504030201,
        64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF,
        64'h0000000000000000, 64'h0A0A0A0A0A0A0A0A,
        64'h0003000700320064, 64'h01010101010101C8 };
    localparam logic [7:0] V_SGN [N_VEC] = '{
        8'h00, 8'hFF, 8'h00, 8'hFF, 8'hAA, 8'h0F, 8'h55, 8'h01 };
    localparam int V_EXP [N_VEC] = '{ 8, -36, 2040, -2040, 0, 0, -160, -193 };
    localparam string V_REQ [N_VEC] = '{ "R2", "R3", "R6", "R6", "R4", "R8", "R4", "R2" };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 valid", int'(out_valid), 0);
        chk("R5 sum", int'(out_sum), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 idle", int'(out_valid), 0);

        // R1: table streamed back to back; result c-4 checked at falling edge c
        for (int c = 0; c < N_VEC + 4; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                chk("R1 valid", int'(out_valid), 1);
                chk(V_REQ[c-4], int'($signed(out_sum)), V_EXP[c-4]);
            end else begin
                chk("R1 fill", int'(out_valid), 0);
            end
            if (c < N_VEC) begin
                in_valid = 1'b1;
                in_mag   = V_MAG[c];
                in_sign  = V_SGN[c];
            end else begin
                in_valid = 1'b0;
            end
        end

        // R7: bubbles keep their place
        begin
            bit pat [6] = '{1, 0, 1, 1, 0, 1};
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (c >= 4) chk("R7", int'(out_valid), int'(pat[c-4]));
                in_valid = (c < 6) ? pat[c] : 1'b0;
                in_mag   = 64'h0202020202020202;
                in_sign  = 8'h00;
            end
        end

        // R4: negative zero on every term alone
        @(negedge clk);
        in_valid = 1'b1; in_mag = 64'h0500000000000000; in_sign = 8'h7F;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 signed zeros", int'($signed(out_sum)), 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule